// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is a management-interface master for Ethernet PHYs. It generates the MDC clock and drives or releases the MDIO line. Software controls it through a single 32-bit command register. One write with the go bit set launches exactly one management frame.

The start code, the opcode, the PHY address, the register/device field and the 16-bit data word are all taken directly from fields of that write. As a result, the same engine produces both Clause 22 and Clause 45 frames. For a Clause 45 access, software first issues an address frame that carries the device in the register field and the target register address in the data field. It polls until the busy flag clears, and only then issues the read or write frame.

While a frame is in flight, the busy flag reads 1 and further writes are ignored. When the flag clears, a read has already placed the 16 bits sampled from the PHY into the data field.

Top module: `mdio_master`

## Requirements
- R1: The command readback is: bit 31 busy, bit 30 always 0, bits 29:25 register/device field, bits 24:20 PHY address, bits 19:18 opcode, bits 17:16 start code, bits 15:0 data. After reset every bit reads 0.
- R2: A write with bit 31 set while idle stores all fields and sets busy from the next clock edge. Busy stays set for exactly 64*CLK_DIV clock cycles and then clears by itself.
- R3: A write while busy is set has no effect: neither the readback fields nor the frame on the wire change.
- R4: A write with bit 31 clear while idle updates bits 29:0 of the readback. It starts no frame: busy, MDC and the MDIO output enable all stay 0.
- R5: During a frame, each bit lasts CLK_DIV clocks. MDC is low for the first CLK_DIV/2 of them and high for the rest. MDC is low whenever the block is idle.
- R6: Each frame is sent MSB first, one bit per MDC rise, in this order: 32 ones, the 2-bit start code, the 2-bit opcode, 5 bits of PHY address, 5 bits of register/device field, 2 turnaround bits, 16 data bits. The start code (0 for Clause 45, 1 for Clause 22) and the opcode (0 Clause 45 address, 1 write, 2 Clause 22 read, 3 Clause 45 read) are sent exactly as written.
- R7: For opcodes 0 and 1, the master drives the turnaround bits as 1 then 0, followed by the 16 data bits from bits 15:0.
- R8: For opcodes 2 and 3, the master releases MDIO (output enable 0) for frame bits 46 to 63. It samples MDIO on the MDC rise of each of bits 48 to 63, MSB first. The 16 sampled bits appear in readback bits 15:0 in the same cycle that busy clears.
- R9: MDIO output and output enable change only at the start of a bit, half an MDC period after a rising edge. They never change while MDC is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWrEn | input | 1 | Write strobe for the command register |
| cmdWrData | input | 32 | Command word being written |
| cmdRdData | output | 32 | Command register readback, including busy |
| mdc | output | 1 | Management clock to the PHYs |
| mdioIn | input | 1 | MDIO line as seen by the master |
| mdioOut | output | 1 | Value the master drives on MDIO |
| mdioOe | output | 1 | MDIO output enable; 0 releases the line |

## Verification
Busy and the stored fields are visible one clock edge after the write. Bit k of the frame is presented on the MDC rise that comes k*CLK_DIV + CLK_DIV/2 edges after the launch edge. Busy and the read data change together, 64*CLK_DIV edges after launch. The bench counts edges from the launch edge and samples every output on the falling clock edge at exactly those counts. It checks busy at the last cycle before the clear and at the clear itself. A responder triggered by MDC captures each transmitted bit on its rise and presents read data in time for the next rise.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int TA_BIT     = 46;
  localparam int DATA_BIT   = 48;

  typedef struct packed {
    logic fieldWr;     // store command fields
    logic load;        // launch: load the frame shifter
    logic shift;       // advance the frame shifter one bit
    logic sample;      // capture mdioIn on this MDC rise
    logic done;        // last cycle of the frame
    logic preamble;    // current bit lies in the preamble
    logic busRelease;  // read frame in turnaround or data phase
  } mdioStrobes_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int CLK_DIV = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic         wrGo,
  input  logic         isRead,
  output logic         busy,
  output logic         mdc,
  output mdioStrobes_t strb
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int CNT_W = $clog2(CLK_DIV);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_DIV - 1);
  localparam logic [CNT_W-1:0] CNT_RISE = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] cnt;
  logic [5:0]       bitIdx;
  logic             cntLast;
  logic             lastBit;

  assign cntLast = (cnt == CNT_LAST);
  assign lastBit = (bitIdx == 6'(FRAME_BITS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      mdc    <= 1'b0;
      cnt    <= '0;
      bitIdx <= '0;
    end else if (!busy) begin
      if (wrEn && wrGo) begin
        busy   <= 1'b1;
        cnt    <= '0;
        bitIdx <= '0;
      end
      mdc <= 1'b0;
    end else if (cntLast) begin
      cnt <= '0;
      mdc <= 1'b0;
      if (lastBit) busy <= 1'b0;
      else         bitIdx <= bitIdx + 6'd1;
    end else begin
      cnt <= cnt + CNT_W'(1);
      if (cnt == CNT_RISE) mdc <= 1'b1;
    end
  end

  always_comb begin
    strb.fieldWr    = wrEn && !busy;
    strb.load       = wrEn && wrGo && !busy;
    strb.shift      = busy && cntLast && (bitIdx >= 6'(PRE_BITS)) && !lastBit;
    strb.sample     = busy && (cnt == CNT_RISE) && isRead && (bitIdx >= 6'(DATA_BIT));
    strb.done       = busy && cntLast && lastBit;
    strb.preamble   = (bitIdx < 6'(PRE_BITS));
    strb.busRelease = isRead && (bitIdx >= 6'(TA_BIT));
  end
endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  mdioStrobes_t strb,
  input  logic         busy,
  input  logic [29:0]  wrFields,
  input  logic         mdioIn,
  output logic [4:0]   regDev,
  output logic [4:0]   phyAddr,
  output logic [1:0]   opCode,
  output logic [1:0]   startCode,
  output logic [15:0]  dataWord,
  output logic         isRead,
  output logic         mdioOut,
  output logic         mdioOe
);
  logic [31:0] frameSh;
  logic [15:0] rdSh;

  assign isRead = opCode[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regDev    <= '0;
      phyAddr   <= '0;
      opCode    <= '0;
      startCode <= '0;
      dataWord  <= '0;
      frameSh   <= '0;
      rdSh      <= '0;
    end else begin
      if (strb.fieldWr) begin
        regDev    <= wrFields[29:25];
        phyAddr   <= wrFields[24:20];
        opCode    <= wrFields[19:18];
        startCode <= wrFields[17:16];
        dataWord  <= wrFields[15:0];
      end else if (strb.done && isRead) begin
        dataWord <= rdSh;
      end
      if (strb.load)
        frameSh <= {wrFields[17:16], wrFields[19:18], wrFields[24:20],
                    wrFields[29:25], 2'b10, wrFields[15:0]};
      else if (strb.shift)
        frameSh <= {frameSh[30:0], 1'b0};
      if (strb.sample)
        rdSh <= {rdSh[14:0], mdioIn};
    end
  end

  assign mdioOut = strb.preamble ? 1'b1 : frameSh[31];
  assign mdioOe  = busy && !strb.busRelease;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int CLK_DIV = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWrEn,
  input  logic [31:0] cmdWrData,
  output logic [31:0] cmdRdData,
  output logic        mdc,
  input  logic        mdioIn,
  output logic        mdioOut,
  output logic        mdioOe
);
  mdioStrobes_t strb;
  logic         busy;
  logic         isRead;
  logic [4:0]   regDev;
  logic [4:0]   phyAddr;
  logic [1:0]   opCode;
  logic [1:0]   startCode;
  logic [15:0]  dataWord;
  logic         unusedSpareBit;

  assign unusedSpareBit = cmdWrData[30];

  mdio_ctrl #(.CLK_DIV(CLK_DIV)) ctrl (
    .clk(clk), .rstN(rstN), .wrEn(cmdWrEn), .wrGo(cmdWrData[31]),
    .isRead(isRead), .busy(busy), .mdc(mdc), .strb(strb)
  );

  mdio_dp dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy),
    .wrFields(cmdWrData[29:0]), .mdioIn(mdioIn),
    .regDev(regDev), .phyAddr(phyAddr), .opCode(opCode),
    .startCode(startCode), .dataWord(dataWord), .isRead(isRead),
    .mdioOut(mdioOut), .mdioOe(mdioOe)
  );

  assign cmdRdData = {busy, 1'b0, regDev, phyAddr, opCode, startCode, dataWord};
endmodule

// File: rtl/mdio_master_sva.sv
module mdio_master_sva (
  input logic        clk,
  input logic        rstN,
  input logic        cmdWrEn,
  input logic        wrGo,
  input logic [31:0] cmdRdData,
  input logic        mdc,
  input logic        mdioOut,
  input logic        mdioOe
);
  assert_launch_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdRdData[31] && cmdWrEn && wrGo) |=> cmdRdData[31]);

  assert_busy_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdRdData[31] && $past(cmdRdData[31])) |-> $stable(cmdRdData[30:0]));

  assert_busy_wr_ignored_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdRdData[31] && cmdWrEn) |=> (cmdRdData[29:16] == $past(cmdRdData[29:16])));

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    !cmdRdData[31] |-> (!mdc && !mdioOe));

  assert_spare_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    !cmdRdData[30]);

  assert_mdio_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (mdc && $past(mdc)) |-> ($stable(mdioOut) && $stable(mdioOe)));
endmodule

bind mdio_master mdio_master_sva sva (
  .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .wrGo(cmdWrData[31]),
  .cmdRdData(cmdRdData), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe)
);

// File: tb/mdio_master_test.sv
module mdio_master_test;
  localparam int DIV  = 8;
  localparam int HALF = DIV / 2;
  localparam int FLEN = 64 * DIV;

  // {go, 0, regDev, phy, op, start, data, phyReadValue}
  localparam logic [47:0] VEC [6] = '{
    {1'b1, 1'b0, 5'h02, 5'h01, 2'd1, 2'd1, 16'hA5C3, 16'h0000},  // C22 write
    {1'b1, 1'b0, 5'h00, 5'h1F, 2'd2, 2'd1, 16'h0000, 16'h1234},  // C22 read
    {1'b1, 1'b0, 5'h1E, 5'h03, 2'd0, 2'd0, 16'h8001, 16'h0000},  // C45 address
    {1'b1, 1'b0, 5'h1E, 5'h03, 2'd1, 2'd0, 16'hFFFF, 16'h0000},  // C45 write
    {1'b1, 1'b0, 5'h1E, 5'h03, 2'd3, 2'd0, 16'h0000, 16'hBEEF},  // C45 read
    {1'b1, 1'b0, 5'h1F, 5'h00, 2'd2, 2'd1, 16'h5555, 16'h0000}   // C22 read of zero
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdWrEn = 1'b0;
  logic [31:0] cmdWrData = '0;
  logic [31:0] cmdRdData;
  logic        mdc;
  logic        mdioIn = 1'b1;
  logic        mdioOut;
  logic        mdioOe;

  int tests = 0;
  int fails = 0;

  logic [15:0] phyRd = '0;
  logic [63:0] capOe = '0;
  logic [63:0] capOut = '0;
  int          edgeCnt = 0;

  always #5 clk = ~clk;

  mdio_master #(.CLK_DIV(DIV)) uut (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData),
    .cmdRdData(cmdRdData), .mdc(mdc), .mdioIn(mdioIn),
    .mdioOut(mdioOut), .mdioOe(mdioOe)
  );

  // PHY responder: capture each bit on MDC rise, present next read bit
  always @(posedge mdc) begin
    capOe[edgeCnt]  <= mdioOe;
    capOut[edgeCnt] <= mdioOut;
    edgeCnt = (edgeCnt + 1) % 64;
    mdioIn  <= (edgeCnt >= 48) ? phyRd[63 - edgeCnt] : 1'b1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic launch(input logic [31:0] cmd);
    @(negedge clk);
    cmdWrEn   = 1'b1;
    cmdWrData = cmd;
    @(negedge clk);
    cmdWrEn = 1'b0;
  endtask

  // Runs one frame from its launch edge; optional stray write mid-frame
  task automatic runFrame(input logic [31:0] cmd, input bit doStray,
                          input logic [31:0] stray);
    int  mdcBad = 0;
    int  holdBad = 0;
    bit  prevMdc;
    bit  prevOut;
    bit  prevOe;
    launch(cmd);
    check(cmdRdData[31] === 1'b1, "R2", "busy after launch", cmdRdData, 32'h8000_0000);
    prevMdc = mdc; prevOut = mdioOut; prevOe = mdioOe;
    for (int j = 1; j <= FLEN; j++) begin
      @(negedge clk);
      cmdWrEn = 1'b0;
      if (doStray && j == 20 * DIV) begin
        cmdWrEn   = 1'b1;
        cmdWrData = stray;
      end
      if (j < 2 * DIV && mdc !== ((j % DIV) >= HALF)) mdcBad++;
      if (mdc && prevMdc && (mdioOut !== prevOut || mdioOe !== prevOe)) holdBad++;
      prevMdc = mdc; prevOut = mdioOut; prevOe = mdioOe;
      if (j == FLEN - 1)
        check(cmdRdData[31] === 1'b1, "R2", "busy at last cycle", {31'd0, cmdRdData[31]}, 32'd1);
    end
    check(cmdRdData[31] === 1'b0, "R2", "busy cleared", {31'd0, cmdRdData[31]}, 32'd0);
    check(mdcBad == 0, "R5", "MDC phase errors", mdcBad, 0);
    check(holdBad == 0, "R9", "MDIO moved while MDC high", holdBad, 0);
  endtask

  task automatic checkFrame(input logic [31:0] cmd, input logic [15:0] rdVal);
    logic [13:0] hdr;
    bit          rd;
    int          bad = 0;
    int          firstBad = -1;
    hdr = {cmd[17:16], cmd[19:18], cmd[24:20], cmd[29:25]};
    rd  = cmd[19];
    for (int k = 0; k < 64; k++) begin
      bit eOe;
      bit eOut;
      eOe  = 1'b1;
      eOut = 1'b1;
      if (k >= 32 && k < 46) eOut = hdr[13 - (k - 32)];
      else if (k >= 46 && rd) eOe = 1'b0;
      else if (k == 46) eOut = 1'b1;
      else if (k == 47) eOut = 1'b0;
      else if (k >= 48) eOut = cmd[63 - k];
      if (capOe[k] !== eOe || (eOe && capOut[k] !== eOut)) begin
        bad++;
        if (firstBad < 0) firstBad = k;
      end
    end
    check(bad == 0, rd ? "R8" : "R7", "frame bits (R6 order), first bad index",
          firstBad, 32'hFFFF_FFFF);
    check(cmdRdData === {2'b00, cmd[29:16], rd ? rdVal : cmd[15:0]},
          rd ? "R8" : "R1", "readback after frame", cmdRdData,
          {2'b00, cmd[29:16], rd ? rdVal : cmd[15:0]});
  endtask

  initial begin
    int wd = 0;
    fork
      begin
        while (wd < 150000) begin
          @(posedge clk);
          wd++;
        end
        fails++;
        tests++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    check(cmdRdData === 32'd0, "R1", "reset readback", cmdRdData, 32'd0);
    check(mdc === 1'b0 && mdioOe === 1'b0, "R5", "idle MDC/oe",
          {30'd0, mdc, mdioOe}, 32'd0);
    rstN = 1'b1;

    // vector table walk
    for (int v = 0; v < 6; v++) begin
      logic [31:0] cmd;
      cmd   = VEC[v][47:16];
      phyRd = VEC[v][15:0];
      runFrame(cmd, 1'b0, 32'd0);
      checkFrame(cmd, VEC[v][15:0]);
    end

    // R3: write during a frame is ignored
    begin
      logic [31:0] cmd;
      cmd   = {1'b1, 1'b0, 5'h0A, 5'h15, 2'd1, 2'd1, 16'h3C96};
      phyRd = 16'h0000;
      runFrame(cmd, 1'b1, {1'b1, 1'b0, 5'h11, 5'h0E, 2'd2, 2'd0, 16'h6969});
      check(cmdRdData[29:0] === cmd[29:0], "R3", "fields after stray write",
            cmdRdData, {2'b00, cmd[29:0]});
      checkFrame(cmd, 16'h0000);
    end

    // R4: idle write without go bit stores fields and starts nothing
    begin
      logic [31:0] cmd;
      int          act = 0;
      cmd = {1'b0, 1'b0, 5'h07, 5'h19, 2'd3, 2'd0, 16'hC0DE};
      launch(cmd);
      for (int j = 0; j < 4 * DIV; j++) begin
        if (mdc !== 1'b0 || mdioOe !== 1'b0 || cmdRdData[31] !== 1'b0) act++;
        @(negedge clk);
      end
      check(act == 0, "R4", "activity after no-go write", act, 0);
      check(cmdRdData === {2'b00, cmd[29:0]}, "R4", "fields after no-go write",
            cmdRdData, {2'b00, cmd[29:0]});
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule